// File: doc/BRIEF.md
# IR run-length sampling receiver

This block is the receive front end for a consumer infrared remote link. It takes the demodulated IR line, can invert its polarity, and samples it at a slow rate derived from the block clock. Short level changes are removed by a programmable glitch filter. The filtered line is then compressed into run-length bytes. Each byte holds the level and how many samples that level lasted. The bytes go into a receive FIFO, which software drains through a small register interface.

A packet opens when a pulse has lasted the programmed active threshold. It closes when the line has stayed at space level for a programmed idle time, and the block then flags packet end. Three conditions can raise the interrupt: the FIFO count exceeding a trigger level, packet end, and an overflow where a byte was dropped because the FIFO was full. Software clears each status flag by writing one to it.

Top module: `irrx_runlen`

## Requirements
- R1: The sample period is `DIV_LO` block clocks when bit 0 of the sampling register (offset 0x08) is 0, and `DIV_HI` block clocks when that bit is 1.
- R2: Each FIFO byte holds the filtered level in bit 7 (1 = pulse, 0 = space) and the run length in samples minus one in bits 6:0. A byte is pushed when the level changes while a packet is open.
- R3: Sampling register bits 7:2 set the filter length F. A new level is accepted only after it has held for F consecutive samples; F = 0 acts as 1. Shorter excursions are absorbed into the surrounding run.
- R4: Sampling register bits 15:8 hold the idle field I. An open packet closes after (I+1)*128 consecutive space samples. Its trailing space is reported as I+1 bytes of 0x7F, and status bit 1 (packet end) is then set.
- R5: Sampling register bits 22:16 hold the active field A, and bit 23 is a multiplier. A packet opens only when a pulse has lasted (A+1) samples, or (A+1)*128 samples when bit 23 is set. Nothing is pushed while no packet is open.
- R6: Bit 2 of the receive register (offset 0x04) inverts the input line before sampling.
- R7: Sampling runs only when control register (offset 0x00) bit 0, bit 1 and both of bits 5:4 are set. Otherwise no samples are taken and no bytes are pushed.
- R8: A run longer than 128 samples is emitted as bytes of length field 127, one for each full 128 samples, followed by one byte for the remainder if there is any.
- R9: A read of the data register (offset 0x14) returns the oldest byte and removes it. It returns 0 when the FIFO is empty. A push into a full FIFO (depth `DEPTH`) drops the byte and sets status bit 0 (overflow).
- R10: The status register (offset 0x10) carries overflow in bit 0, packet end in bit 1, data-available in bit 4, and the FIFO count from bit 8. Writing 1 to a flag bit clears it.
- R11: The interrupt enable register (offset 0x0C) has bit 0 for overflow, bit 1 for packet end and bit 4 for data-available, and holds the trigger level from bit 8. Data-available is set while the count exceeds the level. `irq` is the OR of the enabled flags.
- R12: After reset all registers read 0, the FIFO is empty and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; sample ticks are derived from it |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Demodulated infrared line |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops FIFO at the data offset) |
| addr | input | 5 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle `rd_en` is high |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at four kinds of corner case. The first is a run crossing 128-sample boundaries: a design that splits it wrongly emits a bad remainder byte or an extra byte. The second is a glitch one sample shorter than the filter: a weak filter would break one pulse byte into three. The third is the active threshold, including the multiplied form: a wrong opening point either leaks the space that came before, or loses the 127-length chunk that completes exactly as the packet opens. The fourth covers overflow at the FIFO boundary, the data-available comparison at count equal to the trigger level, and an idle field above zero. A wrong design there would keep the byte that should be dropped, raise the interrupt one entry early, or signal packet end after only 128 samples.

// File: rtl/irrx_runlen.sv
module irrx_runlen #(
  parameter int DEPTH  = 64,
  parameter int DIV_LO = 64,
  parameter int DIV_HI = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_in,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [4:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  localparam int PW  = $clog2(DEPTH);
  localparam int CW  = PW + 1;
  localparam int DCW = $clog2(DIV_HI);
  localparam logic [4:0] A_CTRL = 5'h00;
  localparam logic [4:0] A_RXC  = 5'h04;
  localparam logic [4:0] A_SMP  = 5'h08;
  localparam logic [4:0] A_IEN  = 5'h0C;
  localparam logic [4:0] A_STA  = 5'h10;
  localparam logic [4:0] A_DAT  = 5'h14;

  // configuration registers
  logic          ge_q, rxe_q, inv_q;
  logic [1:0]    md_q;
  logic [23:0]   smp_q;
  logic          ovf_en_q, pe_en_q, dav_en_q;
  logic [CW-1:0] trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ge_q <= 1'b0; rxe_q <= 1'b0; md_q <= 2'b00; inv_q <= 1'b0;
      smp_q <= '0; ovf_en_q <= 1'b0; pe_en_q <= 1'b0; dav_en_q <= 1'b0;
      trig_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL: begin ge_q <= wdata[0]; rxe_q <= wdata[1]; md_q <= wdata[5:4]; end
        A_RXC:  inv_q <= wdata[2];
        A_SMP:  smp_q <= wdata[23:0];
        A_IEN:  begin
          ovf_en_q <= wdata[0]; pe_en_q <= wdata[1]; dav_en_q <= wdata[4];
          trig_q <= wdata[8 +: CW];
        end
        default: ;
      endcase
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^wdata[31:24];

  wire en     = ge_q & rxe_q & (md_q == 2'b11);
  wire sta_wr = wr_en && (addr == A_STA);

  // input synchronizer and sample tick
  logic [1:0]     sy_q;
  logic [DCW-1:0] dcnt_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sy_q <= 2'b00;
    else        sy_q <= {sy_q[0], ir_in ^ inv_q};

  wire [DCW-1:0] div_top = smp_q[0] ? DCW'(DIV_HI - 1) : DCW'(DIV_LO - 1);
  wire           tick    = en && (dcnt_q >= div_top);
  wire           s       = sy_q[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            dcnt_q <= '0;
    else if (!en || tick)  dcnt_q <= '0;
    else                   dcnt_q <= dcnt_q + 1'b1;

  // glitch filter, run-length packer, packet framing
  logic        f_q, cur_q, active_q;
  logic [5:0]  pend_q;
  logic [6:0]  run_q;
  logic [15:0] act_cnt_q;
  logic [16:0] idle_cnt_q;

  wire [6:0]  flt_need = (smp_q[7:2] == 6'd0) ? 7'd1 : {1'b0, smp_q[7:2]};
  wire        differ   = (s != f_q);
  wire        flip     = differ && (({1'b0, pend_q} + 7'd1) >= flt_need);
  wire        fn       = flip ? s : f_q;
  wire [15:0] act_base = {9'd0, smp_q[22:16]} + 16'd1;
  wire [15:0] act_thr  = smp_q[23] ? (act_base << 7) : act_base;
  wire [16:0] idle_thr = ({9'd0, smp_q[15:8]} + 17'd1) << 7;
  wire        activating = !active_q && fn && ((act_cnt_q + 16'd1) >= act_thr);
  wire        ending     = active_q && !fn && ((idle_cnt_q + 17'd1) == idle_thr);
  wire        same       = (fn == cur_q);
  wire        push_vld   = same ? (run_q == 7'd127) : (run_q != 7'd0);
  wire [7:0]  push_byte  = same ? {cur_q, 7'd127} : {cur_q, 7'(run_q - 7'd1)};
  wire        push       = tick && push_vld && (same ? (active_q || activating) : active_q);
  wire        end_evt    = tick && ending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q <= 1'b0; cur_q <= 1'b0; active_q <= 1'b0; pend_q <= '0;
      run_q <= '0; act_cnt_q <= '0; idle_cnt_q <= '0;
    end else if (!en) begin
      f_q <= 1'b0; cur_q <= 1'b0; active_q <= 1'b0; pend_q <= '0;
      run_q <= '0; act_cnt_q <= '0; idle_cnt_q <= '0;
    end else if (tick) begin
      f_q        <= fn;
      pend_q     <= (differ && !flip) ? pend_q + 6'd1 : 6'd0;
      cur_q      <= fn;
      run_q      <= same ? ((run_q == 7'd127) ? 7'd0 : run_q + 7'd1) : 7'd1;
      active_q   <= ending ? 1'b0 : (active_q | activating);
      act_cnt_q  <= (fn && !active_q) ? act_cnt_q + 16'd1 : 16'd0;
      idle_cnt_q <= (fn || !active_q) ? 17'd0 : idle_cnt_q + 17'd1;
    end
  end

  // receive FIFO
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  wire full   = (cnt_q == CW'(DEPTH));
  wire pop    = rd_en && (addr == A_DAT) && (cnt_q != '0);
  wire wr_ok  = push && (!full || pop);
  wire ovf_set = push && full && !pop;

  always_ff @(posedge clk)
    if (wr_ok) mem[wp_q] <= push_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (wr_ok) wp_q <= wp_q + 1'b1;
      if (pop)   rp_q <= rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(wr_ok) - CW'(pop);
    end
  end

  // status flags and interrupt
  logic ovf_q, pe_q, dav_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0; pe_q <= 1'b0; dav_q <= 1'b0;
    end else begin
      ovf_q <= ovf_set | (ovf_q & ~(sta_wr & wdata[0]));
      pe_q  <= end_evt | (pe_q  & ~(sta_wr & wdata[1]));
      dav_q <= (cnt_q > trig_q) | (dav_q & ~(sta_wr & wdata[4]));
    end
  end

  assign irq = (ovf_q & ovf_en_q) | (pe_q & pe_en_q) | (dav_q & dav_en_q);

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin rdata[0] = ge_q; rdata[1] = rxe_q; rdata[5:4] = md_q; end
      A_RXC:  rdata[2] = inv_q;
      A_SMP:  rdata[23:0] = smp_q;
      A_IEN:  begin
        rdata[0] = ovf_en_q; rdata[1] = pe_en_q; rdata[4] = dav_en_q;
        rdata[8 +: CW] = trig_q;
      end
      A_STA:  begin
        rdata[0] = ovf_q; rdata[1] = pe_q; rdata[4] = dav_q;
        rdata[8 +: CW] = cnt_q;
      end
      A_DAT:  if (cnt_q != '0) rdata[7:0] = mem[rp_q];
      default: ;
    endcase
  end

  // assertions
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  a_r9_ovf_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> ($past(cnt_q) == CW'(DEPTH)));
  a_r4_end_closes_packet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pe_q) |-> !active_q);
  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !pop) |=> (cnt_q == $past(cnt_q)));
  a_r5_open_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> f_q);
endmodule

// File: tb/test_irrx_runlen.sv
module test_irrx_runlen;
  localparam int DEPTH = 16;
  localparam int DLO = 4;
  localparam int DHI = 8;
  localparam logic [4:0] A_CTRL = 5'h00, A_RXC = 5'h04, A_SMP = 5'h08;
  localparam logic [4:0] A_IEN = 5'h0C, A_STA = 5'h10, A_DAT = 5'h14;

  logic        clk = 1'b0, rst_n = 1'b0, ir_in = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  irrx_runlen #(.DEPTH(DEPTH), .DIV_LO(DLO), .DIV_HI(DHI)) i_irrx_runlen (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  int div = DLO;
  bit inv = 1'b0;
  int idle_fld = 0;
  logic [7:0] expq[$];

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  // driver: hold a level for n samples, optionally recording expected bytes
  task automatic seg(input bit lvl, input int n, input bit rec);
    ir_in = lvl ^ inv;
    if (rec) begin
      for (int k = 0; k < n / 128; k++) expq.push_back({lvl, 7'd127});
      if (n % 128 != 0) expq.push_back({lvl, 7'(n % 128 - 1)});
    end
    repeat (n * div) @(negedge clk);
  endtask

  task automatic idle_end();
    for (int k = 0; k <= idle_fld; k++) expq.push_back(8'h7F);
    seg(1'b0, (idle_fld + 1) * 128 + 16, 1'b0);
  endtask

  task automatic sta_count(output int c);
    logic [31:0] v;
    bus_rd(A_STA, v);
    c = int'((v >> 8) & 32'h1F);
  endtask

  // monitor: pops every byte the design holds and compares with the queue
  task automatic drain(input string req);
    int c;
    logic [31:0] v;
    sta_count(c);
    check({req, " count"}, c, expq.size());
    for (int k = 0; k < c; k++) begin
      bus_rd(A_DAT, v);
      if (expq.size() != 0) check({req, " byte"}, v, {24'd0, expq.pop_front()});
    end
    expq.delete();
    bus_rd(A_DAT, v);
    check("R9 empty read", v, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    bus_rd(A_CTRL, v); check("R12 ctrl", v, 0);
    bus_rd(A_SMP, v);  check("R12 smp", v, 0);
    bus_rd(A_STA, v);  check("R12 status", v, 0);
    check("R12 irq", irq, 0);

    // R2/R4/R10 basic packet, filter 2, idle 0
    bus_wr(A_SMP, 32'h08);
    bus_wr(A_CTRL, 32'h33);
    seg(0, 20, 0);
    seg(1, 9, 1); seg(0, 5, 1); seg(1, 3, 1); seg(0, 40, 1); seg(1, 12, 1);
    idle_end();
    bus_rd(A_STA, v);
    check("R10 status after packet", v, (6 << 8) | 32'h12);
    drain("R2 basic packet");
    bus_wr(A_STA, 32'h13);

    // R8 long run split
    seg(1, 300, 1);
    idle_end();
    drain("R8 split run");
    bus_wr(A_STA, 32'h13);

    // R4 idle field 1 -> 256 space samples
    bus_wr(A_SMP, 32'h108); idle_fld = 1;
    seg(1, 5, 1);
    seg(0, 200, 0);
    bus_rd(A_STA, v);
    check("R4 no end before 256", (v >> 1) & 1, 0);
    check("R4 partial count", (v >> 8) & 32'h1F, 2);
    seg(0, 72, 0);
    expq.push_back(8'h7F); expq.push_back(8'h7F);
    bus_rd(A_STA, v);
    check("R4 end after 256", (v >> 1) & 1, 1);
    drain("R4 idle field");
    bus_wr(A_STA, 32'h13);

    // R3 glitch filter 4
    bus_wr(A_SMP, 32'h10); idle_fld = 0;
    seg(1, 3, 0); seg(0, 30, 0);
    sta_count(c); check("R3 short pulse ignored", c, 0);
    seg(1, 10, 0); seg(0, 3, 0); seg(1, 10, 0);
    expq.push_back({1'b1, 7'd22});
    seg(0, 20, 1); seg(1, 6, 1);
    idle_end();
    drain("R3 glitch absorbed");
    bus_wr(A_STA, 32'h13);

    // R6 inverted input
    inv = 1'b1; ir_in = 1'b1;
    bus_wr(A_RXC, 32'h4);
    bus_rd(A_RXC, v); check("R6 readback", v, 4);
    seg(0, 20, 0);
    seg(1, 8, 1); seg(0, 8, 1); seg(1, 8, 1);
    idle_end();
    drain("R6 inverted");
    inv = 1'b0; ir_in = 1'b0;
    bus_wr(A_RXC, 32'h0);
    seg(0, 20, 0);
    bus_wr(A_STA, 32'h13);

    // R1 divide select
    bus_wr(A_SMP, 32'h11); div = DHI;
    seg(0, 20, 0);
    seg(1, 7, 1); seg(0, 10, 1); seg(1, 4, 1);
    idle_end();
    drain("R1 slow rate");
    bus_wr(A_SMP, 32'h10); div = DLO;
    seg(0, 20, 0);
    seg(1, 14, 1);
    idle_end();
    drain("R1 fast rate");
    bus_wr(A_STA, 32'h13);

    // R5 active threshold 10 samples
    bus_wr(A_SMP, 32'h0009_0004);
    seg(1, 6, 0); seg(0, 30, 0);
    bus_rd(A_STA, v);
    check("R5 below threshold", v & 32'h1F02, 0);
    seg(1, 15, 1); seg(0, 12, 1); seg(1, 5, 1);
    idle_end();
    drain("R5 threshold");
    bus_wr(A_STA, 32'h13);

    // R5 multiplied threshold 128 samples
    bus_wr(A_SMP, 32'h0080_0004);
    seg(1, 100, 0); seg(0, 20, 0);
    sta_count(c); check("R5 multiplied below", c, 0);
    seg(1, 130, 1); seg(0, 10, 1); seg(1, 3, 1);
    idle_end();
    drain("R5 multiplied");
    bus_wr(A_STA, 32'h13);

    // R7 mode bits incomplete
    bus_wr(A_SMP, 32'h04);
    bus_wr(A_CTRL, 32'h13);
    seg(1, 10, 0); seg(0, 200, 0);
    bus_rd(A_STA, v);
    check("R7 disabled no bytes", v & 32'h1F02, 0);
    bus_wr(A_CTRL, 32'h33);
    seg(0, 20, 0);

    // R9 overflow
    for (int k = 0; k < 12; k++) begin
      seg(1, 3, 1);
      if (k < 11) seg(0, 3, 1);
    end
    idle_end();
    while (expq.size() > DEPTH) void'(expq.pop_back());
    bus_rd(A_STA, v);
    check("R9 overflow status", v, (16 << 8) | 32'h13);
    bus_wr(A_STA, 32'h1);
    bus_rd(A_STA, v);
    check("R10 clear overflow only", v, (16 << 8) | 32'h12);
    drain("R9 first bytes kept");
    bus_wr(A_STA, 32'h13);

    // R11 interrupt
    seg(1, 5, 1); seg(0, 5, 1); seg(1, 5, 1);
    idle_end();
    bus_wr(A_IEN, 32'h0);
    check("R11 all masked", irq, 0);
    bus_wr(A_IEN, 32'h410);
    bus_wr(A_STA, 32'h10);
    repeat (2) @(negedge clk);
    check("R11 count equal level", irq, 0);
    bus_wr(A_IEN, 32'h310);
    repeat (2) @(negedge clk);
    check("R11 count above level", irq, 1);
    bus_wr(A_IEN, 32'h2);
    bus_wr(A_STA, 32'h10);
    repeat (2) @(negedge clk);
    check("R11 packet end irq", irq, 1);
    bus_wr(A_STA, 32'h2);
    repeat (2) @(negedge clk);
    check("R11 packet end cleared", irq, 0);
    drain("R11 packet");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule